// File: doc/BRIEF.md
# UART Baud Tick Source Selector

This block generates the 16x oversampling tick that times a UART's transmitter and receiver. It has four rate sources: two fixed fractions of the core clock, a prescaled version of an external timer-overflow strobe, and a dedicated reloadable 16-bit divider. The UART mode, a rate-doubling input and a source-select control bit decide which source drives the tick output.

Software reaches the block through a small write port with three byte registers: a control register (divider enable and source select), the divisor low byte and the divisor high byte. The divisor bytes are locked while the divider runs, so the divider never loads a divisor that has only been partly written. The control register can be read back at any time.

Top module: `baud_tick_sel`

## Requirements
- R1: After reset the control read-back `ctrl_rdata_o` is 0, so the divider is disabled and the source select is 0.
- R2: With `mode_i` = 0 the tick period is 16 core clocks, whatever the values of `dbl_i`, the source select and the divider enable.
- R3: With `mode_i` = 2 the tick period is 32 core clocks when `dbl_i` = 0 and 16 core clocks when `dbl_i` = 1.
- R4: With `mode_i` = 1 or 3 and source select 0, one tick is issued per 64 `tmr_ovf_i` pulses when `dbl_i` = 0 and per 32 pulses when `dbl_i` = 1. Each such tick falls in a cycle where `tmr_ovf_i` is high.
- R5: With `mode_i` = 1 or 3, source select 1 and the divider enabled, the tick period is {high byte, low byte} + 16 core clocks, and `dbl_i` has no effect.
- R6: While the divider enable is 0, the divider issues no ticks. With `mode_i` = 1 or 3 and source select 1, `tick_o` stays low.
- R7: A write to the divisor low byte (address 1) or high byte (address 2) is ignored while the divider enable is 1. The period that follows is unchanged, including after the divider is disabled and enabled again.
- R8: The control register is at address 0. Bit 0 is the divider enable, bit 1 is the source select, and bits 7..2 read as 0 whatever value was written to them.
- R9: Each tick is a pulse exactly one core clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 divisor low, 2 divisor high |
| reg_wdata_i | input | 8 | Register write data |
| ctrl_rdata_o | output | 8 | Control register read-back |
| mode_i | input | 2 | UART mode 0..3 |
| dbl_i | input | 1 | Rate-doubling control |
| tmr_ovf_i | input | 1 | Timer overflow strobe, one cycle per overflow |
| tick_o | output | 1 | 16x oversampling tick |

## Verification
The bench measures the interval between consecutive ticks for each combination of mode, doubling and source, including the smallest divisor (0, a period of 16) and a divisor that uses both bytes. A divider that dropped the +16 offset or ignored the high byte would give a period that is too short. A doubling input that leaked into mode 0 or the divider path would halve or double those periods. It writes new divisor bytes while the divider runs, then disables and re-enables the divider. A missing lock would show up as a changed period. It holds the divider disabled with the divider source selected to catch any stray tick, and it writes all ones to the control register to catch reserved bits that were stored.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_DIV_LO = 2'd1,
    ADDR_DIV_HI = 2'd2
  } reg_addr_e;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'd0,
    MODE_VAR_A = 2'd1,
    MODE_FIXED = 2'd2,
    MODE_VAR_B = 2'd3
  } uart_mode_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_SEL_BIT = 1;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              en_o,
  output logic              sel_o,
  output logic [DIV_W-1:0]  divisor_o
);
  localparam int unsigned HI_W = DIV_W - 8;

  logic           en_q, sel_q;
  logic [7:0]     lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (we_i) begin
      unique case (reg_addr_e'(addr_i))
        ADDR_CTRL: begin
          en_q  <= wdata_i[CTRL_EN_BIT];
          sel_q <= wdata_i[CTRL_SEL_BIT];
        end
        // divisor bytes are frozen while the divider runs
        ADDR_DIV_LO: if (!en_q) lo_q <= wdata_i;
        ADDR_DIV_HI: if (!en_q) hi_q <= wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign en_o      = en_q;
  assign sel_o     = sel_q;
  assign divisor_o = {hi_q, lo_q};
endmodule

// File: rtl/baud_div.sv
module baud_div #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_OFS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = {1'b0, divisor_i} + CNT_W'(DIV_OFS - 1);
  assign tick_o = en_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pulse_prescale.sv
// Counts qualifying cycles; fast tick every 2**(LOG2-1), slow every 2**LOG2.
module pulse_prescale #(
  parameter int unsigned LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic tick_fast_o,
  output logic tick_slow_o
);
  logic [LOG2-1:0] cnt_q;

  assign tick_fast_o = inc_i && (&cnt_q[LOG2-2:0]);
  assign tick_slow_o = inc_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_tick_sel.sv
module baud_tick_sel
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DIV_OFS   = 16,
  parameter int unsigned CORE_LOG2 = 5,
  parameter int unsigned OVF_LOG2  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        ctrl_rdata_o,
  input  logic [1:0]        mode_i,
  input  logic              dbl_i,
  input  logic              tmr_ovf_i,
  output logic              tick_o
);
  logic             div_en, src_sel;
  logic [DIV_W-1:0] divisor;
  logic             div_tick;
  logic             core_fast, core_slow;
  logic             ovf_fast, ovf_slow;

  baud_regs #(.DIV_W(DIV_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .en_o      (div_en),
    .sel_o     (src_sel),
    .divisor_o (divisor)
  );

  baud_div #(.DIV_W(DIV_W), .DIV_OFS(DIV_OFS)) i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (div_en),
    .divisor_i (divisor),
    .tick_o    (div_tick)
  );

  pulse_prescale #(.LOG2(CORE_LOG2)) i_core_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_i       (1'b1),
    .tick_fast_o (core_fast),
    .tick_slow_o (core_slow)
  );

  pulse_prescale #(.LOG2(OVF_LOG2)) i_ovf_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_i       (tmr_ovf_i),
    .tick_fast_o (ovf_fast),
    .tick_slow_o (ovf_slow)
  );

  always_comb begin
    unique case (uart_mode_e'(mode_i))
      MODE_SHIFT: tick_o = core_fast;
      MODE_FIXED: tick_o = dbl_i ? core_fast : core_slow;
      default:    tick_o = src_sel ? div_tick : (dbl_i ? ovf_fast : ovf_slow);
    endcase
  end

  always_comb begin
    ctrl_rdata_o               = '0;
    ctrl_rdata_o[CTRL_EN_BIT]  = div_en;
    ctrl_rdata_o[CTRL_SEL_BIT] = src_sel;
  end
endmodule

// File: rtl/baud_tick_sel_chk.sv
module baud_tick_sel_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       ctrl_rdata_o,
  input logic [1:0]       mode_i,
  input logic             dbl_i,
  input logic             tmr_ovf_i,
  input logic             tick_o,
  input logic [DIV_W-1:0] divisor
);
  logic odd_mode;
  assign odd_mode = mode_i[0];

  p_ovf_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_mode && !ctrl_rdata_o[1] && tick_o) |-> tmr_ovf_i);

  p_div_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_mode && ctrl_rdata_o[1] && !ctrl_rdata_o[0]) |-> !tick_o);

  p_div_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[0] |=> $stable(divisor));

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(mode_i) && $stable(dbl_i) && $stable(ctrl_rdata_o)) |-> !(tick_o && $past(tick_o)));
endmodule

bind baud_tick_sel baud_tick_sel_chk #(.DIV_W(DIV_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_rdata_o (ctrl_rdata_o),
  .mode_i       (mode_i),
  .dbl_i        (dbl_i),
  .tmr_ovf_i    (tmr_ovf_i),
  .tick_o       (tick_o),
  .divisor      (divisor)
);

// File: tb/test_baud_tick_sel.sv
module test_baud_tick_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] mode = '0;
  logic       dbl = 1'b0;
  logic       ovf = 1'b0;
  logic       tick;

  int n_chk = 0;
  int n_fail = 0;
  int ovf_gap = 0;
  int ovf_cnt = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_sel i_baud_tick_sel (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .ctrl_rdata_o (rdata), .mode_i (mode),
    .dbl_i (dbl), .tmr_ovf_i (ovf), .tick_o (tick)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        dbl;
    logic        sel;
    logic [15:0] div;
    logic [3:0]  gap;
    logic [15:0] period;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b1, 16'd5,   4'd0, 16'd16},  // R2
    '{2'd0, 1'b0, 1'b0, 16'd0,   4'd0, 16'd16},  // R2
    '{2'd2, 1'b0, 1'b0, 16'd0,   4'd0, 16'd32},  // R3
    '{2'd2, 1'b1, 1'b1, 16'd9,   4'd0, 16'd16},  // R3
    '{2'd1, 1'b0, 1'b0, 16'd0,   4'd1, 16'd64},  // R4
    '{2'd3, 1'b1, 1'b0, 16'd0,   4'd2, 16'd64},  // R4
    '{2'd1, 1'b0, 1'b1, 16'd0,   4'd0, 16'd16},  // R5
    '{2'd3, 1'b1, 1'b1, 16'h0105, 4'd0, 16'd277}, // R5
    '{2'd1, 1'b1, 1'b1, 16'd20,  4'd0, 16'd36}   // R5
  };

  // overflow strobe generator
  initial begin
    forever begin
      @(posedge clk); #1;
      ovf = (ovf_gap != 0) && (ovf_cnt % ovf_gap == 0);
      ovf_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  // measure cycles between two ticks, checking single-cycle width (R9)
  task automatic measure(input string req, input int exp);
    int n = 0;
    bit seen = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      seen = tick;
    end
    if (!seen) begin
      check(1'b0, req, 0, exp);
      return;
    end
    seen = 1'b0;
    while (!seen && n < 4000) begin
      @(negedge clk);
      n++;
      if (n == 1) check(!tick, "R9", int'(tick), 0);
      seen = tick && (n > 1);
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic configure(input vec_t v);
    wr(2'd0, 8'h00);
    wr(2'd1, v.div[7:0]);
    wr(2'd2, v.div[15:8]);
    wr(2'd0, {6'd0, v.sel, 1'b1});
    mode = v.mode; dbl = v.dbl; ovf_gap = int'(v.gap);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rdata == 8'h00, "R1", int'(rdata), 0);

    for (int k = 0; k < NV; k++) begin
      configure(VECS[k]);
      measure(k < 2 ? "R2" : k < 4 ? "R3" : k < 6 ? "R4" : "R5", int'(VECS[k].period));
    end

    // R8: reserved bits read zero
    wr(2'd0, 8'hFF);
    @(negedge clk);
    check(rdata == 8'h03, "R8", int'(rdata), 3);

    // R6: divider disabled, divider source selected -> silent
    wr(2'd0, 8'h02);
    mode = 2'd1; dbl = 1'b0; ovf_gap = 1;
    begin
      int cnt = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (tick) cnt++;
      end
      check(cnt == 0, "R6", cnt, 0);
    end

    // R7: divisor writes ignored while enabled
    ovf_gap = 0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd4);
    wr(2'd2, 8'd0);
    wr(2'd0, 8'h03);
    measure("R7", 20);
    wr(2'd1, 8'h50);
    wr(2'd2, 8'h01);
    measure("R7", 20);
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h03);
    measure("R7", 20);

    // R5: doubling has no effect on the divider
    dbl = 1'b1;
    mode = 2'd3;
    repeat (2) @(posedge clk);
    measure("R5", 20);

    // R2: mode 0 ignores a disabled divider and source select
    wr(2'd0, 8'h02);
    mode = 2'd0; dbl = 1'b0;
    measure("R2", 16);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule